// File: doc/BRIEF.md
# Supply-Guarded Strobed Byte Memory

This block is a 2048 x 8 byte store with a strobe-style interface. It emulates a bytewide static memory inside a clocked design. Three active-low strobes are sampled on a fast system clock: chip select, write strobe and read enable. The address and write data are sampled alongside them. A write is open while select and write strobe are both low. The byte is stored when the first of the two strobes returns high, using the address and data seen in the last sampled cycle of the overlap. Reads drive a separate data output together with an enable flag. The enable stands in for a tristate bus driver, so when it is low the output counts as high-impedance.

Two digital supply flags, one for write-protect and one for backup, lock the block. While either flag is set, every strobe is a don't-care, the output enable stays low and nothing is written. Stored bytes are never cleared by reset, by protection or by backup. After the flags clear, the block stays locked until chip select has been seen high. This stops a strobe cycle that began before or during the fault from completing.

The controller is a state machine. Its states are:
- `ST_LOCK`: protected, or waiting for chip select high.
- `ST_IDLE`: deselected.
- `ST_READ`: selected with the write strobe high.
- `ST_WR_TAIL`: write opened by the write strobe falling while already selected.
- `ST_WR_LEAD`: write opened by the write strobe falling before or together with select.
- `ST_HOLDZ`: a lead-opened write has ended but select is still low.

Its transitions are:
- Any state goes to LOCK on a supply flag.
- LOCK goes to IDLE when select is high and no flag is set.
- IDLE goes to READ when select falls with the write strobe high.
- IDLE goes to WR_LEAD when select falls with the write strobe low.
- READ goes to WR_TAIL when the write strobe falls.
- READ goes to IDLE when select rises.
- WR_TAIL goes to READ, and WR_LEAD goes to HOLDZ, when the write ends with select still low.
- Either write state goes to IDLE when the write ends by select rising.
- HOLDZ goes to IDLE when select rises.
- HOLDZ goes to WR_LEAD when the write strobe falls again.

Top module: `nvb_store`

## Requirements
- R1: A byte is stored only at the end of an interval in which select and write strobe are both low. It is stored when the first of the two rises. The stored address and data are the values present in the last sampled cycle of the overlap. All 2048 addresses, 0 through 2047, are reachable.
- R2: `dout_en` is 1 only while select is low, read enable is low and write strobe is high in a read cycle. In that case `dout` carries the byte at `addr`. Otherwise `dout_en` is 0 and `dout` is 0.
- R3: When the write strobe falls while the outputs are driven, `dout_en` drops to 0 even with read enable low. If that write ends by the write strobe rising while select stays low, output resumes and shows the newly written byte.
- R4: If the write strobe falls before or together with select, `dout_en` stays 0 until select rises. This holds even after the write strobe rises while read enable is low.
- R5: While `pwr_prot` or `pwr_backup` is 1, no byte is written and `dout_en` is 0, whatever the strobes do.
- R6: If a supply flag sets while a write interval is open, that write is abandoned and the location keeps its previous byte.
- R7: Stored bytes survive protect and backup periods unchanged.
- R8: After the supply flags clear, and after reset, writes and reads are refused until select has been sampled high at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Active-low reset of control state (array not cleared) |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read output enable, active low |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| pwr_prot | input | 1 | Supply below write-protect threshold |
| pwr_backup | input | 1 | Supply in backup (retention) state |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Output driver enable (0 means high-impedance) |

## Verification
Write commit and the protection lockout can land in the same cycle. A supply flag that arrives while a write interval is open competes with the strobe rise that would store the byte. The bench opens a write and raises the protect flag with the strobes still low. It then releases the strobes while the flag is held, clears the flag, and checks by readback that the location kept its old byte. A second case clears the flag while the strobes are still low and then ends the write, to show that the lockout rather than the flag decides the outcome.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_LOCK    = 3'd0,
        ST_IDLE    = 3'd1,
        ST_READ    = 3'd2,
        ST_WR_TAIL = 3'd3,
        ST_WR_LEAD = 3'd4,
        ST_HOLDZ   = 3'd5
    } nvb_state_e;
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data;

    // Last address/data seen while both strobes were low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (cap_en) begin
            hold_addr <= cap_addr;
            hold_data <= cap_data;
        end
    end

    // Contents have no reset: they persist across every supply state.
    always_ff @(posedge clk) begin
        if (wr_en) mem[hold_addr] <= hold_data;
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_s,
    input  logic we_s,
    input  logic oe_s,
    input  logic prot,
    output logic wr_en,
    output logic drive_en
);
    nvb_state_e st, nxt;
    logic       strobe_or_q;
    logic       end_rise;
    logic       in_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_or_q <= 1'b1;
        else        strobe_or_q <= ce_s | we_s;
    end

    assign end_rise = (ce_s | we_s) & ~strobe_or_q;
    assign in_write = (st == ST_WR_TAIL) || (st == ST_WR_LEAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOCK;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (prot) begin
            nxt = ST_LOCK;
        end else begin
            unique case (st)
                ST_LOCK:    if (ce_s) nxt = ST_IDLE;
                ST_IDLE:    if (!ce_s) nxt = we_s ? ST_READ : ST_WR_LEAD;
                ST_READ: begin
                    if (ce_s)       nxt = ST_IDLE;
                    else if (!we_s) nxt = ST_WR_TAIL;
                end
                ST_WR_TAIL: if (end_rise) nxt = ce_s ? ST_IDLE : ST_READ;
                ST_WR_LEAD: if (end_rise) nxt = ce_s ? ST_IDLE : ST_HOLDZ;
                ST_HOLDZ: begin
                    if (ce_s)       nxt = ST_IDLE;
                    else if (!we_s) nxt = ST_WR_LEAD;
                end
                default:    nxt = ST_LOCK;
            endcase
        end
    end

    always_comb begin
        wr_en    = in_write && end_rise && !prot;
        drive_en = (st == ST_READ) && !ce_s && we_s && !oe_s && !prot;
    end

    AST_WR_AFTER_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(!ce_s && !we_s)); // R1
    AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!ce_s && !oe_s && we_s)); // R2
    AST_WE_KILLS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |-> !drive_en); // R3
    AST_HOLDZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLDZ || st == ST_WR_LEAD) |-> !drive_en); // R4
    AST_PROT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        prot |-> (!drive_en && !wr_en)); // R5
    AST_PROT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> (st == ST_LOCK)); // R6
    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCK) |-> (!wr_en && !drive_en)); // R8
endmodule

// File: rtl/nvb_store.sv
module nvb_store
    import nvb_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DW     = DATA_W,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          pwr_prot,
    input  logic          pwr_backup,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    localparam int BUS_W = AW + DW;

    logic [2:0]       strb_s;
    logic [BUS_W-1:0] bus_s;
    logic             ce_s, we_s, oe_s;
    logic [AW-1:0]    addr_s;
    logic [DW-1:0]    din_s;
    logic             prot;
    logic             wr_en, drive_en;
    logic [DW-1:0]    rd_data;

    nvb_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d({ce_n, we_n, oe_n}), .q(strb_s)
    );

    nvb_sync #(.WIDTH(BUS_W), .STAGES(STAGES), .RST_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
    );

    assign {ce_s, we_s, oe_s} = strb_s;
    assign {addr_s, din_s}    = bus_s;
    assign prot               = pwr_prot | pwr_backup;

    nvb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .we_s(we_s), .oe_s(oe_s),
        .prot(prot), .wr_en(wr_en), .drive_en(drive_en)
    );

    nvb_array #(.ADDR_W(AW), .DATA_W(DW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .cap_en(!ce_s && !we_s), .cap_addr(addr_s), .cap_data(din_s),
        .wr_en(wr_en), .rd_addr(addr_s), .rd_data(rd_data)
    );

    assign dout_en = drive_en;
    assign dout    = drive_en ? rd_data : '0;

    AST_DOUT_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R2
    AST_PROT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_prot || pwr_backup) |-> !dout_en); // R5
endmodule

// File: tb/tb_nvb_store.sv
module tb_nvb_store;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0] din = '0;
    logic       pwr_prot = 1'b0, pwr_backup = 1'b0;
    logic [7:0] dout;
    logic       dout_en;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    nvb_store dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .pwr_prot(pwr_prot), .pwr_backup(pwr_backup),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual en/data=%b/%h expected %b/%h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic rd_expect(input logic [10:0] a, input logic [7:0] exp, input string tag);
        ce_n = 1; we_n = 1; oe_n = 1; tick(3);
        addr = a; ce_n = 0; oe_n = 0; tick(6);
        chk(tag, {dout_en, dout}, {1'b1, exp});
        ce_n = 1; oe_n = 1; tick(4);
    endtask

    // Write strobe leads select; write ends by select rising.
    task automatic wr_lead(input logic [10:0] a, input logic [7:0] d);
        addr = a; din = d; we_n = 0; tick(1);
        ce_n = 0; tick(5);
        ce_n = 1; tick(1);
        we_n = 1; tick(4);
    endtask

    task automatic t_reset;
        chk("R2 reset output off", {dout_en, dout}, 9'h000);
    endtask

    task automatic t_basic_write;
        wr_lead(11'd0, 8'hA5);
        wr_lead(11'd2047, 8'h5C);
        wr_lead(11'd5, 8'h11);
        rd_expect(11'd0, 8'hA5, "R1 write addr 0");
        rd_expect(11'd2047, 8'h5C, "R1 write addr 2047");
    endtask

    task automatic t_last_data;
        addr = 11'd20; din = 8'h01; ce_n = 0; tick(3);
        we_n = 0; tick(3);
        din = 8'h02; tick(3);
        we_n = 1; tick(4);
        ce_n = 1; tick(3);
        rd_expect(11'd20, 8'h02, "R1 last overlap data stored");
    endtask

    task automatic t_read_gating;
        addr = 11'd5; ce_n = 0; oe_n = 1; tick(6);
        chk("R2 read enable high gives Z", {dout_en, dout}, 9'h000);
        ce_n = 1; oe_n = 0; tick(6);
        chk("R2 select high gives Z", {dout_en, dout}, 9'h000);
        oe_n = 1; tick(3);
    endtask

    task automatic t_we_override;
        addr = 11'd5; ce_n = 0; oe_n = 0; tick(6);
        chk("R3 driving before write", {dout_en, dout}, {1'b1, 8'h11});
        din = 8'h5A; we_n = 0; tick(5);
        chk("R3 write strobe disables output", {dout_en, dout}, 9'h000);
        we_n = 1; tick(6);
        chk("R3 output resumes with new byte", {dout_en, dout}, {1'b1, 8'h5A});
        ce_n = 1; oe_n = 1; tick(4);
    endtask

    task automatic t_lead_hiz;
        addr = 11'd7; din = 8'h3C; oe_n = 0; we_n = 0; ce_n = 0; tick(5);
        chk("R4 simultaneous fall stays Z", {dout_en, dout}, 9'h000);
        we_n = 1; tick(6);
        chk("R4 Z after write strobe rises", {dout_en, dout}, 9'h000);
        ce_n = 1; tick(3);
        ce_n = 0; tick(6);
        chk("R4 new cycle drives written byte", {dout_en, dout}, {1'b1, 8'h3C});
        ce_n = 1; oe_n = 1; tick(4);
    endtask

    task automatic t_protect;
        wr_lead(11'd9, 8'h77);
        pwr_prot = 1; tick(2);
        wr_lead(11'd9, 8'hEE);
        addr = 11'd9; ce_n = 0; oe_n = 0; tick(6);
        chk("R5 no output while protected", {dout_en, dout}, 9'h000);
        ce_n = 1; oe_n = 1; tick(3);
        pwr_prot = 0; tick(3);
        rd_expect(11'd9, 8'h77, "R5 protected write ignored");
    endtask

    task automatic t_backup;
        pwr_backup = 1; tick(2);
        wr_lead(11'd0, 8'h00);
        wr_lead(11'd2047, 8'hFF);
        pwr_backup = 0; tick(3);
        rd_expect(11'd0, 8'hA5, "R7 byte kept through backup");
        rd_expect(11'd2047, 8'h5C, "R7 top byte kept through backup");
    endtask

    task automatic t_abort;
        wr_lead(11'd12, 8'h21);
        addr = 11'd12; din = 8'h99; we_n = 0; ce_n = 0; tick(5);
        pwr_prot = 1; tick(3);
        ce_n = 1; we_n = 1; tick(3);
        pwr_prot = 0; tick(3);
        rd_expect(11'd12, 8'h21, "R6 open write abandoned");
    endtask

    task automatic t_lockout;
        pwr_prot = 1; tick(1);
        addr = 11'd12; din = 8'hAB; ce_n = 0; we_n = 0; tick(3);
        pwr_prot = 0; tick(3);
        we_n = 1; tick(4);
        ce_n = 1; tick(4);
        rd_expect(11'd12, 8'h21, "R8 half cycle refused after protect");
        wr_lead(11'd12, 8'hAB);
        rd_expect(11'd12, 8'hAB, "R8 writes resume after select high");
    endtask

    initial begin
        tick(4);
        t_reset();
        rst_n = 1; tick(4);
        t_basic_write();
        t_last_data();
        t_read_gating();
        t_we_override();
        t_lead_hiz();
        t_protect();
        t_backup();
        t_abort();
        t_lockout();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule